// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block sits on a host-facing board bus and feeds a configuration bitstream, one bit at a time, into a chain of programmable devices that load in slave serial fashion. Software arms it by writing a start code to a control I/O port. The block then holds the devices' active-low program line down for a fixed number of clocks, releases it, and waits for the devices to raise their init line.

From then on, every host memory write into the board's window is treated as one configuration bit. The block takes bit 0 of the 16-bit board data bus, places it on the serial data line and produces one configuration clock pulse around it, with setup time before the rising edge and hold through the high phase. A status read of the same I/O port shows the devices' init and done lines and the loader's own progress, so software can poll for readiness before streaming data and for completion afterwards. The mode ends when the devices report done or when software writes an abort code. Once the mode has ended, memory writes no longer produce clocks.

Top module: `cfgSerialLoader`

## Requirements
- R1: After reset the program line is high, the configuration clock is low, serial data is 0 and the active flag is 0.
- R2: Configuration mode is entered only by an I/O write of START_CODE (default 8'hC5) to CTRL_ADDR (default 10'h300); any other address or data value leaves the program line high and the active flag low.
- R3: On entry the program line is driven low for exactly PROG_CYC clock cycles (default 8) and then released.
- R4: After release, memory writes are ignored (no clock pulse) until the device init line has been seen high.
- R5: Each accepted memory write produces exactly one configuration clock pulse, high for HIGH_CYC cycles (default 2), with serial data equal to bit 0 of the bus value of that write.
- R6: Serial data is stable for at least SETUP_CYC cycles (default 2) before the rising clock edge and stays stable while the clock is high.
- R7: A memory write that arrives while a bit is still being shifted is ignored.
- R8: When the device done line goes high while waiting for data, the block leaves configuration mode; later memory writes produce no clock.
- R9: An I/O write of ABORT_CODE (default 8'h3A) to CTRL_ADDR leaves configuration mode from any state and releases the program line high.
- R10: An I/O read of CTRL_ADDR returns bit 0 = init, bit 1 = done, bit 2 = active, bit 3 = ready for data, bits 7:4 = 0; init and done pass through a two-stage synchronizer.
- R11: Memory writes outside configuration mode never produce a clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | I/O write strobe, one cycle per write |
| ioWrAddr | input | 10 | I/O write address |
| ioWrData | input | 8 | I/O write data (command code) |
| ioRdEn | input | 1 | I/O read strobe |
| ioRdAddr | input | 10 | I/O read address |
| ioRdData | output | 8 | Status byte, zero when the read is not for CTRL_ADDR |
| memWrEn | input | 1 | Host memory write strobe into the window, one cycle per write |
| busData | input | 16 | Board data bus; bit 0 carries the configuration bit |
| cfgInit | input | 1 | Device init line, asynchronous |
| cfgDone | input | 1 | Device done line, asynchronous |
| cfgProgN | output | 1 | Active-low program line to the devices |
| cfgClk | output | 1 | Configuration clock to the devices |
| cfgDin | output | 1 | Serial configuration data |
| cfgActive | output | 1 | High while configuration mode is in force |

## Verification
The assertions assume that each strobe is a single-cycle pulse sampled on the rising clock, that init and done may change at any time, and that a restart during the program phase may lengthen the low pulse, which is why the width property checks a minimum. The stimulus drives every strobe for exactly one cycle from the falling edge, keeps the init and done lines at levels that stay put for several cycles, and mixes random bus values, random gaps and stray I/O writes to other addresses with directed cases for back-to-back writes, aborts and writes issued outside the mode.

// File: rtl/cfgLoaderPkg.sv
package cfgLoaderPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAITINIT,
    ST_READY,
    ST_SETUP,
    ST_HIGH
  } cfgStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic latchBit;   // capture bus bit 0 into serial data
    logic driveProg;  // program line low
    logic clkHigh;    // configuration clock high
    logic cntClr;     // restart the phase counter
    logic inMode;     // configuration mode active
    logic accepting;  // waiting for the next data bit
  } cfgStrobeT;

endpackage

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgLoaderPkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobeT        strobe,
  input  logic             busBit,
  input  logic             cfgInit,
  input  logic             cfgDone,
  output logic [CNT_W-1:0] cnt,
  output logic             initSync,
  output logic             doneSync,
  output logic             cfgProgN,
  output logic             cfgClk,
  output logic             cfgDin,
  output logic             cfgActive,
  output logic             cfgReady
);

  logic [SYNC_STAGES-1:0] initPipe;
  logic [SYNC_STAGES-1:0] donePipe;

  // synchronizer chains, one stage per generate step
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) begin
          initPipe[g] <= 1'b0;
          donePipe[g] <= 1'b0;
        end else begin
          initPipe[g] <= cfgInit;
          donePipe[g] <= cfgDone;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) begin
          initPipe[g] <= 1'b0;
          donePipe[g] <= 1'b0;
        end else begin
          initPipe[g] <= initPipe[g-1];
          donePipe[g] <= donePipe[g-1];
        end
      end
    end
  end

  assign initSync = initPipe[SYNC_STAGES-1];
  assign doneSync = donePipe[SYNC_STAGES-1];

  // phase counter
  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // registered outputs to the devices
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgProgN  <= 1'b1;
      cfgClk    <= 1'b0;
      cfgDin    <= 1'b0;
      cfgActive <= 1'b0;
      cfgReady  <= 1'b0;
    end else begin
      cfgProgN  <= ~strobe.driveProg;
      cfgClk    <= strobe.clkHigh;
      cfgActive <= strobe.inMode;
      cfgReady  <= strobe.accepting;
      if (strobe.latchBit) cfgDin <= busBit;
    end
  end

endmodule

// File: rtl/cfgControl.sv
module cfgControl
  import cfgLoaderPkg::*;
#(
  parameter int PROG_CYC  = 8,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 2,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic             abortCmd,
  input  logic             memWrEn,
  input  logic             initSync,
  input  logic             doneSync,
  input  logic [CNT_W-1:0] cnt,
  output cfgStrobeT        strobe
);

  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST  = CNT_W'(HIGH_CYC - 1);

  cfgStateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    strobe.driveProg = (state == ST_PROG);
    strobe.clkHigh   = (state == ST_HIGH);
    strobe.inMode    = (state != ST_IDLE);
    strobe.accepting = (state == ST_READY);

    if (abortCmd) begin
      stateNext = ST_IDLE;
    end else if (startCmd) begin
      stateNext     = ST_PROG;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_IDLE;
        ST_PROG: begin
          if (cnt == PROG_LAST) begin
            stateNext     = ST_WAITINIT;
            strobe.cntClr = 1'b1;
          end
        end
        ST_WAITINIT: begin
          if (initSync) stateNext = ST_READY;
        end
        ST_READY: begin
          if (doneSync) begin
            stateNext = ST_IDLE;
          end else if (memWrEn) begin
            stateNext       = ST_SETUP;
            strobe.latchBit = 1'b1;
            strobe.cntClr   = 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt == SETUP_LAST) begin
            stateNext     = ST_HIGH;
            strobe.cntClr = 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == HIGH_LAST) begin
            stateNext     = ST_READY;
            strobe.cntClr = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgSerialLoader.sv
module cfgSerialLoader
  import cfgLoaderPkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter int          BUS_W       = 16,
  parameter logic [9:0]  CTRL_ADDR   = 10'h300,
  parameter logic [7:0]  START_CODE  = 8'hC5,
  parameter logic [7:0]  ABORT_CODE  = 8'h3A,
  parameter int          PROG_CYC    = 8,
  parameter int          SETUP_CYC   = 2,
  parameter int          HIGH_CYC    = 2,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] ioWrAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioRdAddr,
  output logic [7:0]        ioRdData,
  input  logic              memWrEn,
  input  logic [BUS_W-1:0]  busData,
  input  logic              cfgInit,
  input  logic              cfgDone,
  output logic              cfgProgN,
  output logic              cfgClk,
  output logic              cfgDin,
  output logic              cfgActive
);

  localparam int MAX_A   = (PROG_CYC > SETUP_CYC) ? PROG_CYC : SETUP_CYC;
  localparam int MAX_CYC = (MAX_A > HIGH_CYC) ? MAX_A : HIGH_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CTRL_ADDR);

  cfgStrobeT        strobe;
  logic [CNT_W-1:0] cnt;
  logic             initSync, doneSync, cfgReady;
  logic             ctrlWr, startCmd, abortCmd;
  logic             unusedUpper;

  assign ctrlWr   = ioWrEn && (ioWrAddr == SEL_ADDR);
  assign startCmd = ctrlWr && (ioWrData == START_CODE);
  assign abortCmd = ctrlWr && (ioWrData == ABORT_CODE);
  assign unusedUpper = ^busData[BUS_W-1:1];

  cfgControl #(
    .PROG_CYC (PROG_CYC),
    .SETUP_CYC(SETUP_CYC),
    .HIGH_CYC (HIGH_CYC),
    .CNT_W    (CNT_W)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .startCmd (startCmd),
    .abortCmd (abortCmd),
    .memWrEn  (memWrEn),
    .initSync (initSync),
    .doneSync (doneSync),
    .cnt      (cnt),
    .strobe   (strobe)
  );

  cfgDatapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busBit   (busData[0]),
    .cfgInit  (cfgInit),
    .cfgDone  (cfgDone),
    .cnt      (cnt),
    .initSync (initSync),
    .doneSync (doneSync),
    .cfgProgN (cfgProgN),
    .cfgClk   (cfgClk),
    .cfgDin   (cfgDin),
    .cfgActive(cfgActive),
    .cfgReady (cfgReady)
  );

  always_comb begin
    if (ioRdEn && (ioRdAddr == SEL_ADDR))
      ioRdData = {4'b0000, cfgReady, cfgActive, doneSync, initSync};
    else
      ioRdData = 8'h00;
  end

endmodule

// File: rtl/cfgSerialLoaderChk.sv
module cfgSerialLoaderChk #(
  parameter int PROG_CYC = 8
) (
  input logic clk,
  input logic rstN,
  input logic cfgProgN,
  input logic cfgClk,
  input logic cfgDin,
  input logic cfgActive
);

  int unsigned lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          lowCnt <= 0;
    else if (!cfgProgN) lowCnt <= (lowCnt < 32'hFFFF_0000) ? lowCnt + 1 : lowCnt;
    else                lowCnt <= 0;
  end

  // R1 / R11: outside the mode the device lines are idle
  a_r11_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !cfgActive |-> (cfgProgN && !cfgClk));

  // R2: program line only moves inside the mode
  a_r2_prog_in_mode: assert property (@(posedge clk) disable iff (!rstN)
    !cfgProgN |-> cfgActive);

  // R3: a normal release comes after at least PROG_CYC low cycles
  a_r3_prog_width: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgProgN) && cfgActive) |-> (lowCnt >= PROG_CYC));

  // R5: clock pulses only with the program line released
  a_r5_clk_released: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> cfgProgN);

  // R6: data held while the clock is high
  a_r6_din_stable: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |-> $stable(cfgDin));

endmodule

bind cfgSerialLoader cfgSerialLoaderChk #(.PROG_CYC(PROG_CYC)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgProgN (cfgProgN),
  .cfgClk   (cfgClk),
  .cfgDin   (cfgDin),
  .cfgActive(cfgActive)
);

// File: tb/tb_cfgSerialLoader.sv
`timescale 1ns/1ps
module tb_cfgSerialLoader;

  localparam logic [9:0] CTRL  = 10'h300;
  localparam logic [7:0] START = 8'hC5;
  localparam logic [7:0] ABORT = 8'h3A;
  localparam int PROG_CYC  = 8;
  localparam int SETUP_CYC = 2;
  localparam int HIGH_CYC  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWrEn = 1'b0, ioRdEn = 1'b0, memWrEn = 1'b0;
  logic [9:0] ioWrAddr = '0, ioRdAddr = '0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic [15:0] busData = '0;
  logic cfgInit = 1'b0, cfgDone = 1'b0;
  logic cfgProgN, cfgClk, cfgDin, cfgActive;

  always #10 clk = ~clk;

  cfgSerialLoader dut (
    .clk(clk), .rstN(rstN),
    .ioWrEn(ioWrEn), .ioWrAddr(ioWrAddr), .ioWrData(ioWrData),
    .ioRdEn(ioRdEn), .ioRdAddr(ioRdAddr), .ioRdData(ioRdData),
    .memWrEn(memWrEn), .busData(busData),
    .cfgInit(cfgInit), .cfgDone(cfgDone),
    .cfgProgN(cfgProgN), .cfgClk(cfgClk), .cfgDin(cfgDin), .cfgActive(cfgActive)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // monitor state
  int pulseCnt = 0, capIdx = 0, highRun = 0, badHigh = 0, badSetup = 0;
  int stableCnt = 0, lowRun = 0, lastLowRun = 0, progFalls = 0;
  logic prevClk = 1'b0, prevProg = 1'b1, prevDin = 1'b0;
  logic cap [0:127];
  logic expBits [0:127];
  int expIdx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (cfgDin != prevDin) stableCnt = 0;
      else                   stableCnt++;
      if (cfgClk && !prevClk) begin
        pulseCnt++;
        if (capIdx < 128) cap[capIdx] = cfgDin;
        capIdx++;
        if (stableCnt < SETUP_CYC) badSetup++;
        highRun = 1;
      end else if (cfgClk) begin
        highRun++;
      end else if (prevClk) begin
        if (highRun != HIGH_CYC) badHigh++;
      end
      if (!cfgProgN) begin
        if (prevProg) progFalls++;
        lowRun++;
      end else if (!prevProg) begin
        lastLowRun = lowRun;
        lowRun = 0;
      end
      prevClk = cfgClk; prevProg = cfgProgN; prevDin = cfgDin;
    end
  end

  task automatic ioWrite(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); ioWrEn = 1'b1; ioWrAddr = a; ioWrData = d;
    @(negedge clk); ioWrEn = 1'b0;
  endtask

  task automatic memWrite(input logic [15:0] d);
    @(negedge clk); memWrEn = 1'b1; busData = d;
    @(negedge clk); memWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); ioRdEn = 1'b1; ioRdAddr = a;
    #1 d = ioRdData;
    @(negedge clk); ioRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] st;
    int p0;
    void'($urandom(32'd2718));
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    chk(cfgProgN === 1'b1 && cfgClk === 1'b0 && cfgDin === 1'b0 && cfgActive === 1'b0,
        "R1 reset outputs", {cfgProgN, cfgClk, cfgDin, cfgActive}, 4'b1000);
    ioRead(CTRL, st);
    chk(st == 8'h00, "R10 status after reset", st, 8'h00);

    // R11 write outside mode
    memWrite(16'hFFFF); idle(8);
    chk(pulseCnt == 0, "R11 no pulse outside mode", pulseCnt, 0);

    // R2 wrong address / wrong code
    ioWrite(10'h301, START); ioWrite(CTRL, 8'h00); ioWrite(CTRL, 8'hC4); idle(4);
    chk(progFalls == 0 && cfgActive == 1'b0, "R2 no entry on other writes", progFalls, 0);

    // R3 program pulse
    ioWrite(CTRL, START);
    idle(PROG_CYC + 4);
    chk(progFalls == 1 && lastLowRun == PROG_CYC, "R3 program low width", lastLowRun, PROG_CYC);
    chk(cfgActive == 1'b1 && cfgProgN == 1'b1, "R2 mode entered", cfgActive, 1);

    // R4 writes ignored until init
    memWrite(16'h0001); idle(8);
    chk(pulseCnt == 0, "R4 ignored before init", pulseCnt, 0);
    ioRead(CTRL, st);
    chk(st == 8'h04, "R10 status waiting init", st, 8'h04);

    cfgInit = 1'b1; idle(6);
    ioRead(CTRL, st);
    chk(st == 8'h0D, "R10 status ready", st, 8'h0D);

    // R5/R6 random bit stream with stray I/O writes
    for (int i = 0; i < 40; i++) begin
      logic [15:0] d;
      d = 16'($urandom());
      memWrite(d);
      expBits[expIdx] = d[0]; expIdx++;
      if ($urandom_range(0, 3) == 0) ioWrite(10'($urandom_range(0, 767)), 8'($urandom()));
      idle(SETUP_CYC + HIGH_CYC + 2 + $urandom_range(0, 3));
    end
    chk(pulseCnt == 40, "R5 one pulse per write", pulseCnt, 40);

    // R7 back-to-back: second write falls in the shift
    p0 = pulseCnt;
    @(negedge clk); memWrEn = 1'b1; busData = 16'h0001;
    @(negedge clk); busData = 16'h0000;
    @(negedge clk); memWrEn = 1'b0;
    expBits[expIdx] = 1'b1; expIdx++;
    idle(SETUP_CYC + HIGH_CYC + 6);
    chk(pulseCnt - p0 == 1, "R7 overlapping write ignored", pulseCnt - p0, 1);

    begin
      int mism = 0;
      for (int i = 0; i < expIdx; i++) if (cap[i] !== expBits[i]) mism++;
      chk(mism == 0 && capIdx == expIdx, "R5 serial data equals bus bit 0", mism, 0);
    end
    chk(badHigh == 0, "R5 clock high width", badHigh, 0);
    chk(badSetup == 0, "R6 data setup before rise", badSetup, 0);

    // R8 done exits
    cfgDone = 1'b1; idle(6);
    chk(cfgActive == 1'b0, "R8 exit on done", cfgActive, 0);
    ioRead(CTRL, st);
    chk(st == 8'h03, "R10 status after done", st, 8'h03);
    p0 = pulseCnt;
    memWrite(16'h0001); idle(8);
    chk(pulseCnt == p0, "R8 no clock after exit", pulseCnt - p0, 0);

    // R9 abort during program pulse
    cfgDone = 1'b0; cfgInit = 1'b0; idle(4);
    ioWrite(CTRL, START); idle(2);
    ioWrite(CTRL, ABORT); idle(3);
    chk(cfgProgN == 1'b1 && cfgActive == 1'b0, "R9 abort in program phase",
        {cfgProgN, cfgActive}, 2'b10);

    // R9 abort while ready
    ioWrite(CTRL, START); idle(PROG_CYC + 3);
    cfgInit = 1'b1; idle(6);
    ioWrite(CTRL, ABORT); idle(3);
    p0 = pulseCnt;
    memWrite(16'h0001); idle(8);
    chk(cfgActive == 1'b0 && pulseCnt == p0, "R9 abort from ready", pulseCnt - p0, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule